// File: doc/BRIEF.md
# Buffered-Update SPI Register Port

This block is a serial slave that lets an external controller read and write a 12-bit register address space over SPI. Every transaction opens with a 16-bit command word carrying the direction, a byte count and a start address. Data bytes follow, most significant bit first. When several bytes are carried, each byte goes to the next lower address.

Writes to the general-purpose register window only land in a staging (shadow) copy. The values driven to the rest of the chip (the live copy) change only when the controller sets the commit bit of the update register. That bit clears itself. A readback-select bit chooses whether reads of the window return the staged or the live values. A configuration register picks between a 4-wire mode, where read data leaves on a dedicated output, and a 3-wire mode, where read data is driven back on the shared data pin under an output enable. The same register holds a self-clearing soft-reset bit.

The serial clock, chip select and data input are sampled with the fast system clock. The serial clock must therefore run much slower than the system clock.

Top module: `spi_regport`

## Requirements
- R1: The command word is 16 bits, sent first and MSB first. Bit 15 = 1 selects a read and 0 a write. Bits 14:13 hold the data byte count minus one, so codes 0, 1 and 2 carry 1, 2 or 3 bytes. Bits 11:0 hold the start address. Bit 12 is ignored.
- R2: A write to the general-purpose window (default addresses 0x100 to 0x107, 8 bytes) updates only the staged copy. `act_regs_o` (byte i at bits 8i+7:8i, for address 0x100+i) keeps its value.
- R3: Writing a byte with bit 0 set to address 0x234 copies every staged byte into the live copy one clock later. The bit then reads back as 0.
- R4: In a multi-byte transfer, byte k (k = 0 first) goes to, or comes from, the start address minus k.
- R5: Bit 0 of address 0x004 selects the readback source for the window: 0 returns live values and 1 returns staged values. The other bits of 0x004 read as 0.
- R6: When bit 7 of address 0x000 is 1 (4-wire mode), read data appears on `spi_sdo` and `spi_sdio_oe` stays low.
- R7: When bit 7 of address 0x000 is 0 (3-wire mode), read data appears on `spi_sdio_o` with `spi_sdio_oe` high only during the data bytes of a read. `spi_sdo` stays 0 and the enable drops once chip select goes high.
- R8: Writing a byte with bit 5 set to address 0x000 returns every register (configuration, readback select, staged and live copies) to 0 one clock later. The reset bit therefore reads back as 0.
- R9: Raising chip select before a byte is complete discards that partial byte; no register changes.
- R10: Writes to addresses outside 0x000, 0x004, 0x234 and the window are ignored. Reads from such addresses return 0.
- R11: After reset, `act_regs_o` is 0, `spi_sdo` and `spi_sdio_oe` are low, and the port is in 3-wire mode.
- R12: Serial clocks after the last counted byte of a transaction neither write nor change any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples all serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock; data is taken on its rising edge and driven on its falling edge |
| spi_cs_n | input | 1 | Active-low chip select framing a transaction |
| spi_sdio_i | input | 1 | Serial data in (the shared pin's input side) |
| spi_sdo | output | 1 | Read data in 4-wire mode |
| spi_sdio_o | output | 1 | Read data for the shared pin in 3-wire mode |
| spi_sdio_oe | output | 1 | Output enable of the shared pin |
| act_regs_o | output | 64 | Live copy of the general-purpose window, byte i = address 0x100+i |

## Verification
A wrong live copy shows directly on `act_regs_o`. The bench compares that bus with a behavioural model on every clock once chip select has been high for a few cycles, so a missed or early commit is flagged within one idle gap. A staged copy that is corrupt, misaddressed or wrongly reset stays invisible until it is read back with the readback select set or committed. For that reason every write pattern is followed by a buffered read of the touched and neighbouring addresses. Wrong pin steering in either wire mode shows within the first data bit of a read, because the enable and the unused output are checked at every sampled bit.

// File: rtl/spi_regport_pkg.sv
// Shared constants and types for the SPI register port.
// Assumes a 12-bit address space with byte-wide registers.
package spi_regport_pkg;

    localparam int ADDR_W   = 12;
    localparam int BYTE_W   = 8;
    localparam int INSTR_W  = 16;

    // Command word field positions (decoded by the protocol engine)
    localparam int INS_RD_BIT  = 15;
    localparam int INS_CNT_HI  = 14;
    localparam int INS_CNT_LO  = 13;
    localparam int CNT_W       = INS_CNT_HI - INS_CNT_LO + 1;

    // Fixed control register addresses
    localparam logic [ADDR_W-1:0] ADR_CFG = 12'h000;
    localparam logic [ADDR_W-1:0] ADR_RBK = 12'h004;
    localparam logic [ADDR_W-1:0] ADR_UPD = 12'h234;

    // Configuration register bits
    localparam int CFG_SRST_BIT = 5;
    localparam int CFG_4W_BIT   = 7;

    typedef enum logic [1:0] {
        PH_INSTR = 2'd0,
        PH_DATA  = 2'd1,
        PH_DONE  = 2'd2
    } phase_t;

endpackage

// File: rtl/spi_regport_sync.sv
// Brings the serial pins into the system clock domain and reports edges.
// Assumes the serial clock is much slower than clk (several clk per half period).
module spi_regport_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic din_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_idle,
    output logic din
);

    logic [STAGES:0] sclk_p;
    logic [STAGES:0] cs_p;
    logic [STAGES:0] din_p;

    // Purpose: shift each pin through its synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_p <= '0;
            cs_p   <= '1;
            din_p  <= '0;
        end else begin
            sclk_p <= {sclk_p[STAGES-1:0], sclk_i};
            cs_p   <= {cs_p[STAGES-1:0], cs_n_i};
            din_p  <= {din_p[STAGES-1:0], din_i};
        end
    end

    assign sclk_rise = sclk_p[STAGES-1] & ~sclk_p[STAGES];
    assign sclk_fall = ~sclk_p[STAGES-1] & sclk_p[STAGES];
    assign cs_idle   = cs_p[STAGES-1];
    assign din       = din_p[STAGES-1];

endmodule

// File: rtl/spi_regport_proto.sv
// Serial protocol engine: collects the command word, counts data bytes,
// issues byte writes and serializes read data.
// Assumes edge pulses and data arrive aligned from the synchronizer.
module spi_regport_proto
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_idle,
    input  logic              din,
    input  logic              four_wire,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdio_o,
    output logic              sdio_oe
);

    localparam int BIT_CW = $clog2(INSTR_W);
    localparam logic [BIT_CW-1:0] INSTR_LAST = BIT_CW'(INSTR_W - 1);
    localparam logic [BIT_CW-1:0] BYTE_LAST  = BIT_CW'(BYTE_W - 1);

    phase_t              phase_q;
    logic [INSTR_W-1:0]  ins_sh_q;
    logic [INSTR_W-1:0]  instr_full;
    logic [BIT_CW-1:0]   bit_cnt_q;
    logic [CNT_W-1:0]    left_q;
    logic                rd_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [BYTE_W-1:0]   rx_q;
    logic [BYTE_W-1:0]   tx_q;
    logic                dout_q;
    logic                instr_done;
    logic                byte_done;
    logic                rd_phase;

    assign instr_full = {ins_sh_q[INSTR_W-2:0], din};
    assign instr_done = !cs_idle && sclk_rise && (phase_q == PH_INSTR)
                        && (bit_cnt_q == INSTR_LAST);
    assign byte_done  = !cs_idle && sclk_rise && (phase_q == PH_DATA)
                        && (bit_cnt_q == BYTE_LAST);

    // Read address: decoded start address while the command completes, next lower afterwards
    assign rd_addr = (phase_q == PH_INSTR) ? instr_full[ADDR_W-1:0] : addr_q - 1'b1;

    // Purpose: sequence command and data phases on rising serial edges
    always_ff @(posedge clk) begin
        if (!rst_n || cs_idle) begin
            phase_q   <= PH_INSTR;
            bit_cnt_q <= '0;
            ins_sh_q  <= '0;
            left_q    <= '0;
            rd_q      <= 1'b0;
            addr_q    <= '0;
            rx_q      <= '0;
        end else if (sclk_rise) begin
            case (phase_q)
                PH_INSTR: begin
                    ins_sh_q <= instr_full;
                    if (bit_cnt_q == INSTR_LAST) begin
                        phase_q   <= PH_DATA;
                        bit_cnt_q <= '0;
                        rd_q      <= instr_full[INS_RD_BIT];
                        left_q    <= instr_full[INS_CNT_HI:INS_CNT_LO];
                        addr_q    <= instr_full[ADDR_W-1:0];
                    end else begin
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                end
                PH_DATA: begin
                    rx_q <= {rx_q[BYTE_W-2:0], din};
                    if (bit_cnt_q == BYTE_LAST) begin
                        bit_cnt_q <= '0;
                        addr_q    <= addr_q - 1'b1;
                        if (left_q == '0) begin
                            phase_q <= PH_DONE;
                        end else begin
                            left_q <= left_q - 1'b1;
                        end
                    end else begin
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Purpose: load read bytes at byte boundaries and shift them out on falling edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= '0;
            dout_q <= 1'b0;
        end else if ((instr_done && instr_full[INS_RD_BIT]) ||
                     (byte_done && rd_q && (left_q != '0))) begin
            tx_q <= rd_data;
        end else if (!cs_idle && sclk_fall && (phase_q == PH_DATA) && rd_q) begin
            dout_q <= tx_q[BYTE_W-1];
            tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
        end
    end

    // Purpose: issue one write request per completed write byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= byte_done && !rd_q;
            wr_addr <= addr_q;
            wr_data <= {rx_q[BYTE_W-2:0], din};
        end
    end

    assign rd_phase = (phase_q == PH_DATA) && rd_q;
    assign sdio_oe  = rd_phase && !four_wire;
    assign sdio_o   = sdio_oe && dout_q;
    assign sdo      = rd_phase && four_wire && dout_q;

endmodule

// File: rtl/spi_regport_regs.sv
// Register file: configuration, readback select, commit strobe and a
// staged/live general-purpose window. Assumes one write request per clock at most.
module spi_regport_regs
    import spi_regport_pkg::*;
#(
    parameter logic [ADDR_W-1:0] GP_BASE  = 12'h100,
    parameter int                GP_COUNT = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [BYTE_W-1:0]            wr_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [BYTE_W-1:0]            rd_data,
    output logic                         four_wire,
    output logic                         upd_pend,
    output logic                         srst_pend,
    output logic [GP_COUNT*BYTE_W-1:0]   act_flat,
    output logic [GP_COUNT*BYTE_W-1:0]   shd_flat
);

    localparam int GP_W = GP_COUNT * BYTE_W;

    logic [BYTE_W-1:0]   cfg_q;
    logic                rbk_q;
    logic                upd_q;
    logic [GP_W-1:0]     shd_q;
    logic [GP_W-1:0]     act_q;
    logic [GP_COUNT-1:0] wr_hit;
    logic [GP_COUNT-1:0] rd_hit;
    logic [GP_W-1:0]     rd_src;

    // Per-register address match for the window
    for (genvar gi = 0; gi < GP_COUNT; gi++) begin : g_hit
        localparam logic [ADDR_W-1:0] REG_ADR = GP_BASE + ADDR_W'(gi);
        assign wr_hit[gi] = wr_en && (wr_addr == REG_ADR);
        assign rd_hit[gi] = (rd_addr == REG_ADR);
    end

    assign srst_pend = cfg_q[CFG_SRST_BIT];
    assign four_wire = cfg_q[CFG_4W_BIT];
    assign upd_pend  = upd_q;

    // Purpose: configuration register; its reset bit wipes everything one clock later
    always_ff @(posedge clk) begin
        if (!rst_n || srst_pend) begin
            cfg_q <= '0;
        end else if (wr_en && (wr_addr == ADR_CFG)) begin
            cfg_q <= wr_data;
        end
    end

    // Purpose: readback source select bit
    always_ff @(posedge clk) begin
        if (!rst_n || srst_pend) begin
            rbk_q <= 1'b0;
        end else if (wr_en && (wr_addr == ADR_RBK)) begin
            rbk_q <= wr_data[0];
        end
    end

    // Purpose: commit strobe, high for exactly one clock after being written
    always_ff @(posedge clk) begin
        if (!rst_n || srst_pend) begin
            upd_q <= 1'b0;
        end else begin
            upd_q <= wr_en && (wr_addr == ADR_UPD) && wr_data[0];
        end
    end

    // Purpose: staged and live copies of the window
    always_ff @(posedge clk) begin
        if (!rst_n || srst_pend) begin
            shd_q <= '0;
            act_q <= '0;
        end else begin
            for (int i = 0; i < GP_COUNT; i++) begin
                if (wr_hit[i]) begin
                    shd_q[i*BYTE_W +: BYTE_W] <= wr_data;
                end
            end
            if (upd_q) begin
                act_q <= shd_q;
            end
        end
    end

    assign rd_src = rbk_q ? shd_q : act_q;

    // Purpose: read multiplexer, zero for unmapped addresses
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADR_CFG) begin
            rd_data = cfg_q;
        end else if (rd_addr == ADR_RBK) begin
            rd_data = {{(BYTE_W-1){1'b0}}, rbk_q};
        end else if (rd_addr == ADR_UPD) begin
            rd_data = {{(BYTE_W-1){1'b0}}, upd_q};
        end else begin
            for (int i = 0; i < GP_COUNT; i++) begin
                if (rd_hit[i]) begin
                    rd_data = rd_src[i*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    assign act_flat = act_q;
    assign shd_flat = shd_q;

endmodule

// File: rtl/spi_regport.sv
// Top level of the SPI register port: synchronizer, protocol engine, register file.
// Assumes spi_sclk is at least four clk periods per half cycle.
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter logic [ADDR_W-1:0] GP_BASE     = 12'h100,
    parameter int                GP_COUNT    = 8,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        spi_sclk,
    input  logic                        spi_cs_n,
    input  logic                        spi_sdio_i,
    output logic                        spi_sdo,
    output logic                        spi_sdio_o,
    output logic                        spi_sdio_oe,
    output logic [GP_COUNT*BYTE_W-1:0]  act_regs_o
);

    logic                       sclk_rise_w;
    logic                       sclk_fall_w;
    logic                       cs_idle_w;
    logic                       din_w;
    logic                       four_wire_w;
    logic [BYTE_W-1:0]          rd_data_w;
    logic [ADDR_W-1:0]          rd_addr_w;
    logic                       wr_en_w;
    logic [ADDR_W-1:0]          wr_addr_w;
    logic [BYTE_W-1:0]          wr_data_w;
    logic                       upd_pend_w;
    logic                       srst_pend_w;
    logic [GP_COUNT*BYTE_W-1:0] shd_flat_w;

    spi_regport_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (spi_sclk),
        .cs_n_i    (spi_cs_n),
        .din_i     (spi_sdio_i),
        .sclk_rise (sclk_rise_w),
        .sclk_fall (sclk_fall_w),
        .cs_idle   (cs_idle_w),
        .din       (din_w)
    );

    spi_regport_proto u_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise_w),
        .sclk_fall (sclk_fall_w),
        .cs_idle   (cs_idle_w),
        .din       (din_w),
        .four_wire (four_wire_w),
        .rd_data   (rd_data_w),
        .rd_addr   (rd_addr_w),
        .wr_en     (wr_en_w),
        .wr_addr   (wr_addr_w),
        .wr_data   (wr_data_w),
        .sdo       (spi_sdo),
        .sdio_o    (spi_sdio_o),
        .sdio_oe   (spi_sdio_oe)
    );

    spi_regport_regs #(
        .GP_BASE  (GP_BASE),
        .GP_COUNT (GP_COUNT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en_w),
        .wr_addr   (wr_addr_w),
        .wr_data   (wr_data_w),
        .rd_addr   (rd_addr_w),
        .rd_data   (rd_data_w),
        .four_wire (four_wire_w),
        .upd_pend  (upd_pend_w),
        .srst_pend (srst_pend_w),
        .act_flat  (act_regs_o),
        .shd_flat  (shd_flat_w)
    );

endmodule

// File: rtl/spi_regport_chk.sv
// Assertion checker for the SPI register port, bound to the top module.
module spi_regport_chk #(
    parameter int GP_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_idle,
    input logic            sdio_oe,
    input logic            wr_en,
    input logic            upd_pend,
    input logic            srst_pend,
    input logic [GP_W-1:0] act_flat,
    input logic [GP_W-1:0] shd_flat
);

    AST_OE_DROPS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> !sdio_oe); // R7

    AST_UPD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pend |=> !upd_pend); // R3

    AST_UPD_COPIES_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pend && !srst_pend) |=> (act_flat == $past(shd_flat))); // R3

    AST_LIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_pend && !srst_pend) |=> $stable(act_flat)); // R2

    AST_SRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        srst_pend |=> !srst_pend); // R8

    AST_SRST_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        srst_pend |=> ((act_flat == '0) && (shd_flat == '0))); // R8

    AST_WRITE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(!cs_idle)); // R9

endmodule

bind spi_regport spi_regport_chk #(
    .GP_W (GP_COUNT * spi_regport_pkg::BYTE_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_idle   (cs_idle_w),
    .sdio_oe   (spi_sdio_oe),
    .wr_en     (wr_en_w),
    .upd_pend  (upd_pend_w),
    .srst_pend (srst_pend_w),
    .act_flat  (act_regs_o),
    .shd_flat  (shd_flat_w)
);

// File: tb/spi_regport_tb.sv
// Self-checking bench: behavioural register model, SPI master tasks,
// per-clock comparison of the live copy while the bus is idle.
module spi_regport_tb_top;

    localparam int H       = 8;      // clk cycles per serial half period
    localparam int NREG    = 8;
    localparam int GP_LO   = 'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_sdio_i = 1'b0;
    logic        spi_sdo;
    logic        spi_sdio_o;
    logic        spi_sdio_oe;
    logic [63:0] act_regs_o;

    int tests = 0;
    int fails = 0;
    int mon_checks = 0;
    int mon_prints = 0;
    int quiet = 0;
    bit done = 1'b0;

    logic [7:0] m_shd [NREG];
    logic [7:0] m_act [NREG];
    logic [7:0] m_cfg;
    logic       m_rbk;
    logic [7:0] rd_buf [3];
    bit         pin_bad;

    always #4 clk = ~clk;   // 125 MHz

    spi_regport dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sclk    (spi_sclk),
        .spi_cs_n    (spi_cs_n),
        .spi_sdio_i  (spi_sdio_i),
        .spi_sdo     (spi_sdo),
        .spi_sdio_o  (spi_sdio_o),
        .spi_sdio_oe (spi_sdio_oe),
        .act_regs_o  (act_regs_o)
    );

    // ---------------- model ----------------
    task automatic model_reset();
        for (int i = 0; i < NREG; i++) begin
            m_shd[i] = 8'h00;
            m_act[i] = 8'h00;
        end
        m_cfg = 8'h00;
        m_rbk = 1'b0;
    endtask

    task automatic model_write(input int a, input logic [7:0] d);
        if (a == 'h000) begin
            if (d[5]) model_reset();
            else m_cfg = d;
        end else if (a == 'h004) begin
            m_rbk = d[0];
        end else if (a == 'h234) begin
            if (d[0]) for (int i = 0; i < NREG; i++) m_act[i] = m_shd[i];
        end else if (a >= GP_LO && a < GP_LO + NREG) begin
            m_shd[a - GP_LO] = d;
        end
    endtask

    function automatic logic [7:0] model_read(input int a);
        if (a == 'h000) return m_cfg;
        if (a == 'h004) return {7'b0, m_rbk};
        if (a == 'h234) return 8'h00;
        if (a >= GP_LO && a < GP_LO + NREG)
            return m_rbk ? m_shd[a - GP_LO] : m_act[a - GP_LO];
        return 8'h00;
    endfunction

    function automatic logic [63:0] model_live();
        logic [63:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = m_act[i];
        return v;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check(input string req, input logic [63:0] actual, input logic [63:0] expected);
        tests++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, actual, expected);
        end
    endtask

    // Idle counter and per-clock live-copy comparison (R2, R3)
    always @(posedge clk) quiet <= spi_cs_n ? quiet + 1 : 0;

    always @(negedge clk) begin
        if (rst_n && quiet >= 10) begin
            mon_checks++;
            if (act_regs_o !== model_live()) begin
                fails++;
                if (mon_prints < 5) begin
                    mon_prints++;
                    $display("FAIL R2/R3 live copy actual=%h expected=%h", act_regs_o, model_live());
                end
            end
        end
    end

    // ---------------- SPI master ----------------
    task automatic cs_begin();
        @(negedge clk) spi_cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic cs_end();
        repeat (H) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    // One serial bit: drive, wait, sample the read pins, rise, wait, fall
    task automatic bit_io(input logic b, input bit data_rd, output logic line);
        spi_sdio_i = b;
        repeat (H) @(negedge clk);
        line = m_cfg[7] ? spi_sdo : spi_sdio_o;
        if (data_rd) begin
            if (spi_sdio_oe !== !m_cfg[7]) pin_bad = 1'b1;
            if (!m_cfg[7] && spi_sdo !== 1'b0) pin_bad = 1'b1;
        end else if (spi_sdio_oe !== 1'b0) begin
            pin_bad = 1'b1;
        end
        spi_sclk = 1'b1;
        repeat (H) @(negedge clk);
        spi_sclk = 1'b0;
    endtask

    task automatic send_instr(input bit rd, input int n, input int addr);
        logic [15:0] w;
        logic        dummy;
        w = {rd, 2'(n - 1), 1'b0, 12'(addr)};
        for (int i = 15; i >= 0; i--) bit_io(w[i], 1'b0, dummy);
    endtask

    task automatic send_byte(input logic [7:0] d);
        logic dummy;
        for (int i = 7; i >= 0; i--) bit_io(d[i], 1'b0, dummy);
    endtask

    // Write n bytes (d[0] to addr, d[1] to addr-1, ...) plus extra uncounted bytes
    task automatic spi_write(input int addr, input int n, input logic [7:0] d0,
                             input logic [7:0] d1, input logic [7:0] d2, input int extra);
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        pin_bad = 1'b0;
        cs_begin();
        send_instr(1'b0, n, addr);
        for (int k = 0; k < n; k++) begin
            send_byte(d[k]);
            model_write((addr - k) & 'hFFF, d[k]);
        end
        for (int k = 0; k < extra; k++) send_byte(8'hEE);
        cs_end();
    endtask

    // Read n bytes into rd_buf; pin_bad reports wrong steering of the read pins
    task automatic spi_read(input int addr, input int n, output logic [7:0] exp_b [3]);
        logic line;
        for (int k = 0; k < 3; k++) exp_b[k] = model_read((addr - k) & 'hFFF);
        pin_bad = 1'b0;
        cs_begin();
        send_instr(1'b1, n, addr);
        for (int k = 0; k < n; k++) begin
            for (int i = 7; i >= 0; i--) begin
                bit_io(1'b0, 1'b1, line);
                rd_buf[k][i] = line;
            end
        end
        cs_end();
    endtask

    task automatic read_check(input string req, input int addr, input int n);
        logic [7:0] e [3];
        spi_read(addr, n, e);
        for (int k = 0; k < n; k++) check(req, {56'b0, rd_buf[k]}, {56'b0, e[k]});
        check({req, " pins"}, {63'b0, pin_bad}, 64'd0);
        check({req, " oe idle"}, {63'b0, spi_sdio_oe}, 64'd0);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic dummy;
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R11: reset state
        check("R11 live copy", act_regs_o, 64'd0);
        check("R11 oe", {63'b0, spi_sdio_oe}, 64'd0);
        check("R11 sdo", {63'b0, spi_sdo}, 64'd0);
        read_check("R11 cfg 3-wire read", 'h000, 1);

        // R2: staged write leaves live copy alone
        spi_write('h100, 1, 8'hA5, 8'h00, 8'h00, 0);
        check("R2 live unchanged", act_regs_o, 64'd0);
        read_check("R5 live readback", 'h100, 1);
        spi_write('h004, 1, 8'hFF, 8'h00, 8'h00, 0);
        read_check("R5 select reads only bit0", 'h004, 1);
        read_check("R5 R7 staged readback 3-wire", 'h100, 1);

        // R1 R4: three-byte write, descending addresses
        spi_write('h103, 3, 8'h11, 8'h22, 8'h33, 0);
        read_check("R4 R1 multi-byte staged read", 'h103, 3);
        read_check("R4 two-byte read", 'h101, 2);

        // R3: commit
        spi_write('h234, 1, 8'h01, 8'h00, 8'h00, 0);
        check("R3 live after commit", act_regs_o, model_live());
        read_check("R3 commit bit self-clears", 'h234, 1);

        // R5: live versus staged after a new staged write
        spi_write('h004, 1, 8'h00, 8'h00, 8'h00, 0);
        spi_write('h101, 1, 8'h5A, 8'h00, 8'h00, 0);
        read_check("R5 live value kept", 'h101, 1);
        spi_write('h004, 1, 8'h01, 8'h00, 8'h00, 0);
        read_check("R5 staged value", 'h101, 1);

        // R6: 4-wire mode
        spi_write('h000, 1, 8'h80, 8'h00, 8'h00, 0);
        read_check("R6 4-wire multi-byte read", 'h103, 3);
        read_check("R6 4-wire cfg read", 'h000, 1);

        // R9: partial byte aborted by chip select
        pin_bad = 1'b0;
        cs_begin();
        send_instr(1'b0, 1, 'h105);
        for (int i = 0; i < 5; i++) bit_io(1'b1, 1'b0, dummy);
        cs_end();
        read_check("R9 aborted byte not written", 'h105, 1);

        // R12: bytes beyond the count
        spi_write('h106, 1, 8'h77, 8'h00, 8'h00, 1);
        read_check("R12 counted byte written", 'h106, 1);
        read_check("R12 extra byte ignored", 'h105, 1);

        // R10: unmapped address
        spi_write('h050, 1, 8'hFF, 8'h00, 8'h00, 0);
        read_check("R10 unmapped reads zero", 'h050, 1);
        read_check("R10 window intact", 'h103, 3);

        // commit again so the soft reset has live data to clear
        spi_write('h234, 1, 8'h01, 8'h00, 8'h00, 0);
        check("R3 second commit", act_regs_o, model_live());

        // R8: soft reset (bit5) with 4-wire bit also set
        spi_write('h000, 1, 8'hA0, 8'h00, 8'h00, 0);
        check("R8 live cleared", act_regs_o, 64'd0);
        read_check("R8 cfg cleared, 3-wire again", 'h000, 1);
        read_check("R8 select cleared", 'h004, 1);
        spi_write('h004, 1, 8'h01, 8'h00, 8'h00, 0);
        read_check("R8 staged cleared", 'h106, 1);

        // R7: oe low after chip select returns high, sdo quiet in 3-wire
        check("R7 oe after read", {63'b0, spi_sdio_oe}, 64'd0);
        check("R7 sdo quiet", {63'b0, spi_sdo}, 64'd0);

        if (mon_checks > 0) tests++;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule